// File: doc/BRIEF.md
# Completion Queue Poster with Phase Tag

This block turns a stream of finished-command records into status entries for a circular completion queue that lives in host memory. Command executors hand it a record made of the submission queue number, the command number and a status value. Records may come from any number of submission queues. The block writes each record into the slot at the current tail, one memory write per record, and then moves the tail on by one.

Every entry also carries a phase bit. The host polls that bit to find fresh entries, so it never needs to read a register. The bit value the block writes flips each time the tail wraps from the last slot back to slot zero. The host reports how far it has consumed by writing a head doorbell. The block compares its tail with that head and stalls its input rather than overwrite a slot the host has not yet read. A ring of DEPTH slots therefore holds at most DEPTH-1 unread entries.

Top module: `cq_poster`

## Requirements
- R1: After reset the tail and the head are both slot 0 and the phase value is 1. No memory write is pending, `q_full` is low and `cpl_ready` is high.
- R2: Each record accepted (`cpl_valid` and `cpl_ready` high at a clock edge) produces exactly one memory write. The write is offered from the next cycle at `mem_slot` equal to the tail. Records are written in arrival order, and the tail then advances by one, modulo DEPTH.
- R3: The queue is full when (tail + 1) mod DEPTH equals the head. While it is full, `q_full` is high, `cpl_ready` is low and no record is accepted.
- R4: The phase bit written is 1 on the first pass through the ring. It inverts each time the tail wraps from DEPTH-1 to 0.
- R5: The entry layout, for the default widths, is: command id in bits [15:0], submission queue id in [23:16], phase in bit 24 and status in [39:25]. For other widths the same fields are packed in the same order from bit 0 upward.
- R6: A doorbell write (`db_wr_en` high) with a value below DEPTH becomes the new head on the next edge, which frees slots. A doorbell value of DEPTH or more is ignored and leaves the head unchanged.
- R7: While `mem_valid` is high and `mem_ready` is low, the offered write holds its slot and data stable. A new record is accepted only in a cycle where the pending write completes or no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpl_valid | input | 1 | A completion record is offered |
| cpl_ready | output | 1 | The block takes the offered record this cycle |
| cpl_sqid | input | SQID_W | Submission queue id of the record |
| cpl_cid | input | CID_W | Command id of the record |
| cpl_status | input | STAT_W | Status value, passed through unchanged |
| db_wr_en | input | 1 | Head doorbell write strobe |
| db_head | input | PTR_W+1 | New head slot written by the host |
| mem_valid | output | 1 | An entry write is offered to memory |
| mem_ready | input | 1 | Memory accepts the offered write |
| mem_slot | output | PTR_W | Ring slot the entry goes to |
| mem_data | output | STAT_W+1+SQID_W+CID_W | Packed entry: status, phase, sqid, cid |
| q_full | output | 1 | Ring full; input is stalled |

## Verification
The bench builds the block with DEPTH=5. This ring size is not a power of two, so the explicit wrap from slot 4 to slot 0 is exercised rather than a natural counter rollover. The short ring also lets roughly sixty records make more than ten passes, which flips the phase bit many times, and lets the queue reach full within four records. The 4-bit doorbell port can carry values 5 to 15, so the rejected-head path is reachable. The default widths keep the entry layout at 40 bits, as stated in R5.

// File: rtl/cq_pkg.sv
package cq_pkg;

    // Default geometry of the completion ring and its entry fields.
    localparam int unsigned CQ_DEF_DEPTH  = 16;
    localparam int unsigned CQ_DEF_SQID_W = 8;
    localparam int unsigned CQ_DEF_CID_W  = 16;
    localparam int unsigned CQ_DEF_STAT_W = 15;

endpackage

// File: rtl/cq_tail_ctr.sv
module cq_tail_ctr #(
    parameter int unsigned DEPTH = cq_pkg::CQ_DEF_DEPTH,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [PTR_W-1:0] tail_q,
    output logic             phase_q
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] tail;
        logic             phase;
    } tail_st_t;

    tail_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            if (st_q.tail == LAST) begin
                st_d.tail  = '0;
                st_d.phase = ~st_q.phase;
            end else begin
                st_d.tail = st_q.tail + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.tail  <= '0;
            st_q.phase <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign tail_q  = st_q.tail;
    assign phase_q = st_q.phase;

    // R4: leaving the last slot flips the phase value
    p_phase_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && tail_q == LAST) |=> (phase_q != $past(phase_q)));

    // R4: the phase value holds within a pass
    p_phase_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(adv && tail_q == LAST) |=> $stable(phase_q));

endmodule

// File: rtl/cq_head_reg.sv
module cq_head_reg #(
    parameter int unsigned DEPTH = cq_pkg::CQ_DEF_DEPTH,
    localparam int unsigned PTR_W  = $clog2(DEPTH),
    localparam int unsigned HPTR_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [HPTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0]  head_q
);

    localparam logic [HPTR_W-1:0] LIMIT = HPTR_W'(DEPTH);

    logic [PTR_W-1:0] hd_d, hd_q;
    logic             in_range;

    assign in_range = (wr_ptr < LIMIT);

    always_comb begin
        hd_d = hd_q;
        if (wr_en && in_range) begin
            hd_d = wr_ptr[PTR_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hd_q <= '0;
        end else begin
            hd_q <= hd_d;
        end
    end

    assign head_q = hd_q;

    // R6: out-of-range doorbell values leave the head alone
    p_head_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ptr >= LIMIT) |=> $stable(head_q));

    // R6: a valid doorbell value is taken as the new head
    p_head_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ptr < LIMIT) |=> (HPTR_W'(head_q) == $past(wr_ptr)));

endmodule

// File: rtl/cq_poster.sv
module cq_poster #(
    parameter int unsigned DEPTH  = cq_pkg::CQ_DEF_DEPTH,
    parameter int unsigned SQID_W = cq_pkg::CQ_DEF_SQID_W,
    parameter int unsigned CID_W  = cq_pkg::CQ_DEF_CID_W,
    parameter int unsigned STAT_W = cq_pkg::CQ_DEF_STAT_W,
    localparam int unsigned PTR_W   = $clog2(DEPTH),
    localparam int unsigned HPTR_W  = PTR_W + 1,
    localparam int unsigned ENTRY_W = STAT_W + 1 + SQID_W + CID_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpl_valid,
    output logic               cpl_ready,
    input  logic [SQID_W-1:0]  cpl_sqid,
    input  logic [CID_W-1:0]   cpl_cid,
    input  logic [STAT_W-1:0]  cpl_status,
    input  logic               db_wr_en,
    input  logic [HPTR_W-1:0]  db_head,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic [PTR_W-1:0]   mem_slot,
    output logic [ENTRY_W-1:0] mem_data,
    output logic               q_full
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic               vld;
        logic [PTR_W-1:0]   slot;
        logic [ENTRY_W-1:0] data;
    } wr_st_t;

    wr_st_t           wr_d, wr_q;
    logic [PTR_W-1:0] tail, head, tail_next;
    logic             phase;
    logic             accept;
    logic             full;

    cq_tail_ctr #(.DEPTH(DEPTH)) u_tail (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (accept),
        .tail_q  (tail),
        .phase_q (phase)
    );

    cq_head_reg #(.DEPTH(DEPTH)) u_head (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (db_wr_en),
        .wr_ptr (db_head),
        .head_q (head)
    );

    assign tail_next = (tail == LAST) ? '0 : tail + 1'b1;
    assign full      = (tail_next == head);
    assign cpl_ready = !full && (!wr_q.vld || mem_ready);
    assign accept    = cpl_valid && cpl_ready;

    always_comb begin
        wr_d = wr_q;
        if (wr_q.vld && mem_ready) begin
            wr_d.vld = 1'b0;
        end
        if (accept) begin
            wr_d.vld  = 1'b1;
            wr_d.slot = tail;
            wr_d.data = {cpl_status, phase, cpl_sqid, cpl_cid};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
        end else begin
            wr_q <= wr_d;
        end
    end

    assign mem_valid = wr_q.vld;
    assign mem_slot  = wr_q.slot;
    assign mem_data  = wr_q.data;
    assign q_full    = full;

    // R3: nothing is taken while the ring is full
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !(cpl_valid && cpl_ready));

    // R2: an accepted record is offered next cycle at the old tail
    p_post_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_ready) |=> (mem_valid && mem_slot == $past(tail)));

    // R7: a stalled write keeps its slot and data
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_slot) && $stable(mem_data)));

    // R7: no accept while the pending write is stalled
    p_no_accept_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |-> !cpl_ready);

endmodule

// File: tb/cq_poster_tb_top.sv
`timescale 1ns/1ps
module cq_poster_tb_top;

    localparam int D = 5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpl_valid;
    logic        cpl_ready;
    logic [7:0]  cpl_sqid;
    logic [15:0] cpl_cid;
    logic [14:0] cpl_status;
    logic        db_wr_en;
    logic [3:0]  db_head;
    logic        mem_valid;
    logic        mem_ready;
    logic [2:0]  mem_slot;
    logic [39:0] mem_data;
    logic        q_full;

    always #2.5 clk = ~clk;

    cq_poster #(.DEPTH(D), .SQID_W(8), .CID_W(16), .STAT_W(15)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
        .cpl_sqid(cpl_sqid), .cpl_cid(cpl_cid), .cpl_status(cpl_status),
        .db_wr_en(db_wr_en), .db_head(db_head),
        .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_slot(mem_slot), .mem_data(mem_data), .q_full(q_full)
    );

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 0;
    bit  host_on = 0;

    // behavioural model state
    int          m_tail, m_head, m_phase, p_slot, done_ptr;
    bit          p_vld;
    logic [39:0] p_data;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // model: compare, then advance to the state after the coming edge
    always @(negedge clk) begin
        #1;
        if (!rst_n) begin
            m_tail = 0; m_head = 0; m_phase = 1; p_vld = 0; p_slot = 0; p_data = '0; done_ptr = 0;
        end else begin
            bit m_full, m_rdy;
            m_full = (((m_tail + 1) % D) == m_head);
            m_rdy  = !m_full && (!p_vld || mem_ready);
            chk(q_full === m_full, "R3 q_full", q_full, m_full);
            chk(cpl_ready === m_rdy, "R3 R7 cpl_ready", cpl_ready, m_rdy);
            chk(mem_valid === p_vld, "R2 R7 mem_valid", mem_valid, p_vld);
            if (p_vld) begin
                chk(mem_slot === 3'(p_slot), "R2 mem_slot", mem_slot, p_slot);
                chk(mem_data[24] === p_data[24], "R4 phase bit", mem_data[24], p_data[24]);
                chk(mem_data === p_data, "R5 entry", mem_data, p_data);
            end
            if (p_vld && mem_ready) begin
                p_vld = 0;
                done_ptr = (p_slot + 1) % D;
            end
            if (cpl_valid && m_rdy) begin
                p_vld  = 1;
                p_slot = m_tail;
                p_data = {cpl_status, 1'(m_phase), cpl_sqid, cpl_cid};
                m_tail = (m_tail + 1) % D;
                if (m_tail == 0) m_phase = 1 - m_phase;
            end
            if (db_wr_en && db_head < D) m_head = db_head;
        end
    end

    // host side: random memory backpressure and doorbell writes
    initial begin
        forever begin
            @(negedge clk);
            if (host_on) begin
                mem_ready = ($urandom % 4) != 0;
                db_wr_en  = ($urandom % 3) == 0;
                db_head   = (($urandom % 8) == 0) ? 4'd6 + 4'($urandom % 10) : 4'(done_ptr);
            end
        end
    end

    task automatic send(input logic [7:0] sq, input logic [15:0] cid, input logic [14:0] st);
        @(negedge clk);
        cpl_valid = 1; cpl_sqid = sq; cpl_cid = cid; cpl_status = st;
        #1.5;
        while (!cpl_ready) begin
            @(negedge clk);
            #1.5;
        end
        @(negedge clk);
        cpl_valid = 0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R2 watchdog expired actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 0; cpl_valid = 0; cpl_sqid = 0; cpl_cid = 0; cpl_status = 0;
        db_wr_en = 0; db_head = 0; mem_ready = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #2;
        chk(cpl_ready === 1'b1, "R1 ready after reset", cpl_ready, 1);
        chk(mem_valid === 1'b0, "R1 no write after reset", mem_valid, 0);
        chk(q_full === 1'b0, "R1 not full after reset", q_full, 0);

        // fill the ring: D-1 entries fit
        for (int i = 0; i < D - 1; i++) send(8'(i), 16'(16'h100 + i), 15'(15'h7000 + i));
        #2;
        chk(q_full === 1'b1, "R3 full after D-1 posts", q_full, 1);
        chk(cpl_ready === 1'b0, "R3 stalled when full", cpl_ready, 0);

        // out-of-range doorbell is ignored
        @(negedge clk); db_wr_en = 1; db_head = 4'd9;
        @(negedge clk); db_wr_en = 0;
        #2;
        chk(q_full === 1'b1, "R6 bad head ignored", q_full, 1);

        // valid doorbell frees slots
        @(negedge clk); db_wr_en = 1; db_head = 4'd2;
        @(negedge clk); db_wr_en = 0;
        #2;
        chk(q_full === 1'b0, "R6 head write frees slots", q_full, 0);

        // memory stall: pending write must hold
        @(negedge clk); mem_ready = 0;
        send(8'h33, 16'hbeef, 15'h1234);
        #2;
        chk(mem_valid === 1'b1, "R7 write pending", mem_valid, 1);
        chk(mem_slot === 3'd4, "R2 slot after wrap region", mem_slot, 4);
        chk(mem_data[24] === 1'b1, "R4 phase first pass", mem_data[24], 1);
        chk(cpl_ready === 1'b0, "R7 no accept during stall", cpl_ready, 0);
        @(negedge clk); mem_ready = 1;

        // random long run across many passes
        host_on = 1;
        for (int k = 0; k < 60; k++) begin
            send(8'($urandom), 16'($urandom), 15'($urandom));
            if ($urandom % 3 == 0) repeat ($urandom % 3) @(negedge clk);
        end
        host_on = 0;
        @(negedge clk); mem_ready = 1; db_wr_en = 0;
        repeat (6) @(negedge clk);
        finished = 1;
        summary();
        $finish;
    end

endmodule